// File: doc/BRIEF.md
# Run-Length Configuration Bit Expander

This block turns a byte-coded, run-length compressed configuration stream into a plain serial bit stream. Each code byte stands for a run of identical bits. The run's polarity, its length, and whether one closing bit of the opposite value follows all depend on which of four code ranges the byte falls in. The run threshold `RUN_LIMIT` (default 226) sets where the ranges split.

Bytes come in on a valid/ready port. Bits leave on a valid/ready port that can feed a serial configuration shifter directly. A byte is taken only once every bit of the previous code has been accepted downstream. One down-counter and a pending-closer flag hold the work that remains for the current code. Compressing the stream and handling any sync prefix are left to the surrounding logic.

Top module: `rle_bit_expander`

## Requirements
- R1: While reset is asserted and right after it, `out_valid` is 0 and `in_ready` is 1.
- R2: A code n with 1 <= n <= RUN_LIMIT produces n one-bits, then one zero-bit.
- R3: The code RUN_LIMIT+1 produces RUN_LIMIT one-bits and no closing bit.
- R4: A code n with RUN_LIMIT+2 <= n <= 254 produces n-(RUN_LIMIT+2) zero-bits, then one one-bit. For the code RUN_LIMIT+2 this is the single one-bit alone.
- R5: The code 255 produces a single one-bit.
- R6: The code 0 produces no bit, and `in_ready` is still 1 in the cycle after it is taken.
- R7: `in_ready` is 1 exactly when no bit of an accepted code is still waiting. No byte is taken while `out_valid` is 1.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_bit` hold their values into the next cycle.
- R9: A nonzero code taken at a clock edge makes `out_valid` 1 in the very next cycle. `in_ready` returns to 1 in the cycle after the last bit of a code is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_byte | input | 8 | Compressed code byte |
| in_valid | input | 1 | `in_byte` is offered |
| in_ready | output | 1 | Block can take a byte |
| out_bit | output | 1 | Expanded configuration bit |
| out_valid | output | 1 | `out_bit` is offered |
| out_ready | input | 1 | Downstream takes `out_bit` |

## Verification
A byte accepted at a clock edge has its first bit valid one cycle later. `in_ready` rises one cycle after the edge at which the final bit of a code is taken. A zero code leaves `in_ready` high in the following cycle. The bench keeps a queue model that it updates only from the handshakes it sees at each edge, and it compares `in_ready`, `out_valid` and `out_bit` against that model at every falling edge. This places every expected value in exactly the cycle given above, whether `out_ready` is held high or toggles pseudo-randomly.

// File: rtl/rlx_pkg.sv
package rlx_pkg;
  localparam int CODE_W = 8;

  // Work order produced from one code byte.
  typedef struct packed {
    logic [CODE_W-1:0] run_len;   // number of run bits
    logic              run_val;   // polarity of the run
    logic              has_term;  // a closing bit follows the run
    logic              term_val;  // value of the closing bit
  } rlx_cmd_t;
endpackage

// File: rtl/rlx_code_decode.sv
module rlx_code_decode
  import rlx_pkg::*;
#(
  parameter int RUN_LIMIT = 226
) (
  input  logic [CODE_W-1:0] code,
  output rlx_cmd_t          cmd
);
  localparam logic [CODE_W-1:0] LIM_B  = CODE_W'(RUN_LIMIT);
  localparam logic [CODE_W-1:0] ONLY_1 = CODE_W'(RUN_LIMIT + 1);
  localparam logic [CODE_W-1:0] Z_BASE = CODE_W'(RUN_LIMIT + 2);
  localparam logic [CODE_W-1:0] TOP_C  = {CODE_W{1'b1}};

  always_comb begin
    cmd = '0;
    if (code == '0) begin
      cmd = '0;                       // empty code
    end else if (code <= LIM_B) begin
      cmd.run_len  = code;            // ones, closed by a zero
      cmd.run_val  = 1'b1;
      cmd.has_term = 1'b1;
      cmd.term_val = 1'b0;
    end else if (code == ONLY_1) begin
      cmd.run_len  = LIM_B;           // ones, no closer
      cmd.run_val  = 1'b1;
    end else if (code != TOP_C) begin
      cmd.run_len  = code - Z_BASE;   // zeros, closed by a one
      cmd.run_val  = 1'b0;
      cmd.has_term = 1'b1;
      cmd.term_val = 1'b1;
    end else begin
      cmd.has_term = 1'b1;            // lone one
      cmd.term_val = 1'b1;
    end
  end
endmodule

// File: rtl/rlx_bit_sequencer.sv
module rlx_bit_sequencer
  import rlx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  rlx_cmd_t cmd,
  input  logic     out_ready,
  output logic     idle,
  output logic     out_bit,
  output logic     out_valid
);
  logic [CODE_W-1:0] cnt_q, cnt_d;
  logic              run_val_q, run_val_d;
  logic              term_q, term_d;
  logic              term_val_q, term_val_d;
  logic              run_live, out_fire;

  assign run_live  = (cnt_q != '0);
  assign out_valid = run_live || term_q;
  assign out_bit   = run_live ? run_val_q : term_val_q;
  assign idle      = !out_valid;
  assign out_fire  = out_valid && out_ready;

  always_comb begin
    cnt_d      = cnt_q;
    run_val_d  = run_val_q;
    term_d     = term_q;
    term_val_d = term_val_q;
    if (load) begin
      cnt_d      = cmd.run_len;
      run_val_d  = cmd.run_val;
      term_d     = cmd.has_term;
      term_val_d = cmd.term_val;
    end else if (out_fire) begin
      if (run_live) cnt_d  = cnt_q - 1'b1;
      else          term_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      run_val_q  <= 1'b0;
      term_q     <= 1'b0;
      term_val_q <= 1'b0;
    end else if (load || out_fire) begin
      cnt_q      <= cnt_d;
      run_val_q  <= run_val_d;
      term_q     <= term_d;
      term_val_q <= term_val_d;
    end
  end

  // R2: every accepted run bit shortens the remaining run by exactly one
  a_r2_run_step: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fire && run_live) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R7: a load never lands while bits of an earlier code are pending
  a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !out_valid);

  // R9: accepting the closer empties the sequencer
  a_r9_closer_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fire && !run_live) |=> idle);
endmodule

// File: rtl/rle_bit_expander.sv
module rle_bit_expander
  import rlx_pkg::*;
#(
  parameter int RUN_LIMIT = 226
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] in_byte,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              out_bit,
  output logic              out_valid,
  input  logic              out_ready
);
  rlx_cmd_t cmd;
  logic     idle, in_fire;

  assign in_ready = idle;
  assign in_fire  = in_valid && idle;

  rlx_code_decode #(.RUN_LIMIT(RUN_LIMIT)) u_dec (
    .code (in_byte),
    .cmd  (cmd)
  );

  rlx_bit_sequencer u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (in_fire),
    .cmd       (cmd),
    .out_ready (out_ready),
    .idle      (idle),
    .out_bit   (out_bit),
    .out_valid (out_valid)
  );

  // R8: a stalled bit holds its value
  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bit)));

  // R9: a nonzero code yields a valid bit on the next cycle
  a_r9_first_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (in_byte != '0)) |=> out_valid);

  // R6: a zero code leaves the input side open
  a_r6_zero_code: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (in_byte == '0)) |=> in_ready);

  // R5: the top code offers a one-bit first
  a_r5_top_code: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (in_byte == '1)) |=> (out_valid && out_bit));
endmodule

// File: tb/sim_rle_bit_expander.sv
module sim_rle_bit_expander;
  localparam int M = 226;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] in_byte;
  logic       in_valid;
  logic       in_ready;
  logic       out_bit;
  logic       out_valid;
  logic       out_ready;

  int vectors = 0;
  int misses  = 0;
  int cycles  = 0;
  int rdy_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit   exp_q[$];
  string bit_tag = "R2";
  bit   done = 0;

  always #5 clk = ~clk;

  rle_bit_expander #(.RUN_LIMIT(M)) u0 (
    .clk(clk), .rst_n(rst_n), .in_byte(in_byte), .in_valid(in_valid),
    .in_ready(in_ready), .out_bit(out_bit), .out_valid(out_valid),
    .out_ready(out_ready)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %b expected %b at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // Expansion written straight from the code ranges.
  task automatic push_code(input int n);
    if (n == 0) return;
    if (n <= M) begin
      bit_tag = "R2";
      for (int i = 0; i < n; i++) exp_q.push_back(1'b1);
      exp_q.push_back(1'b0);
    end else if (n == M + 1) begin
      bit_tag = "R3";
      for (int i = 0; i < M; i++) exp_q.push_back(1'b1);
    end else if (n <= 254) begin
      bit_tag = "R4";
      for (int i = 0; i < n - (M + 2); i++) exp_q.push_back(1'b0);
      exp_q.push_back(1'b1);
    end else begin
      bit_tag = "R5";
      exp_q.push_back(1'b1);
    end
  endtask

  // Reference model: compare at every falling edge, then apply the handshakes
  // that will take effect at the next rising edge.
  always @(negedge clk) begin
    cycles++;
    if (!rst_n) begin
      chk("R1 in_ready", in_ready, 1'b1);
      chk("R1 out_valid", out_valid, 1'b0);
    end else if (!done) begin
      chk("R7 in_ready", in_ready, exp_q.size() == 0);
      chk(out_ready ? "R9 out_valid" : "R8 out_valid", out_valid, exp_q.size() != 0);
      if (exp_q.size() != 0) begin
        chk(out_ready ? bit_tag : "R8 out_bit", out_bit, exp_q[0]);
        if (out_valid && out_ready) void'(exp_q.pop_front());
      end
      if (in_valid && in_ready) begin
        if (in_byte == 8'd0) bit_tag = "R6";
        push_code(int'(in_byte));
      end
    end
  end

  // Downstream ready pattern.
  always @(posedge clk) begin
    #1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready <= (rdy_mode == 0) ? 1'b1 : lfsr[3];
  end

  task automatic send(input logic [7:0] b);
    @(posedge clk); #1;
    in_byte  = b;
    in_valid = 1'b1;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic pass();
    send(8'd1);   send(8'd5);   send(8'd226); send(8'd227);
    send(8'd228); send(8'd229); send(8'd240); send(8'd254);
    send(8'd255); send(8'd0);   send(8'd0);   send(8'd3);
    send(8'd255); send(8'd228); send(8'd2);
    for (int k = 0; k < 12; k++) send(8'($urandom_range(0, 255)));
    repeat (300) @(posedge clk);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_byte = 8'd0; out_ready = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    rdy_mode = 0; pass();
    rdy_mode = 1; pass();
    done = 1;
    chk("R7 drained", exp_q.size() == 0, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    misses++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule